// File: doc/BRIEF.md
# HD Line Number and CRC Inserter

This block sits in the transmit path of a high-definition serial digital video link. Upstream, a video source provides two parallel 10-bit word streams, luma (Y) and chroma (C), one word per channel per transfer, together with the 11-bit number of the current line. The block watches both channels for the timing reference that closes active video. In the four transfers straight after that reference, it replaces the incoming words on both channels: first with two words carrying the encoded line number, then with two words carrying that channel's own 18-bit CRC.

Each channel's CRC is kept in its own register. The register clears at the timing reference that opens active video. It then accumulates every word sent on that channel, including the closing reference and the two inserted line-number words. The result feeds a scrambler stage on the same clock through a single register stage.

Both edges of the block are valid/ready streams. A transfer takes place on a rising clock edge where valid and ready are both high. The input ready is high whenever the output register is empty or is being drained in the same cycle. While the output is valid and not taken, the output words and valid do not change, and the input is held off. No word is dropped, duplicated or reordered.

Top module: `hd_ln_crc_insert`

## Requirements
- R1: While and straight after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` = !`out_valid` || `out_ready`. A word pair accepted on one edge is presented on the outputs from that edge on (one register of latency). While `out_valid` is high and `out_ready` low, the outputs hold their value.
- R3: Every accepted word that is not in one of the four insertion slots leaves unchanged on its own channel, in order.
- R4: An end reference is an accepted word whose bit 6 is 1, preceded on the same channel by the accepted words 0x3FF, 0x000, 0x000. Insertion happens only when both channels show it on the same transfer. A word with bit 6 = 0 after that same prefix is a start reference and causes no insertion. Detection is off while slots are being filled.
- R5: Slot 1 (the first transfer after the end reference) carries line bits 6:0 in word bits 8:2, with bit 9 = NOT bit 8 and bits 1:0 = 0. It is the same on both channels.
- R6: Slot 2 carries line bits 10:7 in word bits 5:2, with bit 9 = 1 and all other bits 0. It is the same on both channels.
- R7: Each channel's CRC uses x^18+x^5+x^4+1. It takes data bits LSB first per word. For each bit d: f = crc[0]^d; crc = crc>>1; if f, crc ^= 0x23000 (bits 17, 13, 12).
- R8: A start reference, seen on both channels on the same transfer outside the slots, clears the CRC to 0. That reference word is not included. Every later word as sent is included, up to and including slot 2. No word after slot 2 is included until the next start reference.
- R9: Slot 3 carries CRC bits 8:0 and slot 4 carries CRC bits 17:9, in word bits 8:0, with bit 9 = NOT bit 8. Each channel carries its own CRC.
- R10: The line number used is the value on `in_ln` on the transfer that carries the end reference. Its value on any other transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word pair is present |
| in_ready | output | 1 | Block can take the input word pair |
| in_y | input | 10 | Luma input word |
| in_c | input | 10 | Chroma input word |
| in_ln | input | 11 | Current line number |
| out_valid | output | 1 | Output word pair is present |
| out_ready | input | 1 | Downstream takes the output word pair |
| out_y | output | 10 | Luma output word |
| out_c | output | 10 | Chroma output word |

## Verification
The assertions assume that reset is applied before the first transfer and that `out_ready` may change freely from cycle to cycle. They also assume that upstream never places a reference prefix so that it overlaps the four insertion slots. The stimulus builds whole lines: blanking, then a start reference, then active words confined to 0x004..0x3FB, then an end reference, four filler slot words and more blanking. It throttles both `in_valid` and `out_ready` with a pseudo-random pattern, so stalls land on every slot position. Some lines carry the end reference on luma only, to exercise the rule that both channels must agree. The line number input is held at a wrong value everywhere except on the reference word.

// File: rtl/hdins_pkg.sv
package hdins_pkg;
  localparam int WORD_W = 10;
  localparam int LN_W   = 11;
  localparam int CRC_W  = 18;
  localparam int LN_LO  = 7;

  typedef enum logic [2:0] {
    K_PASS = 3'd0,
    K_LN0  = 3'd1,
    K_LN1  = 3'd2,
    K_CRC0 = 3'd3,
    K_CRC1 = 3'd4
  } slot_e;

  // reflected taps for x^18 + x^5 + x^4 + 1
  localparam logic [CRC_W-1:0] CRC_TAPS =
    (CRC_W'(1) << (CRC_W-1)) | (CRC_W'(1) << (CRC_W-1-4)) | (CRC_W'(1) << (CRC_W-1-5));

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic [WORD_W-1:0] w);
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = cur;
    for (int b = 0; b < WORD_W; b++) begin
      fb  = acc[0] ^ w[b];
      acc = (acc >> 1) ^ (fb ? CRC_TAPS : '0);
    end
    return acc;
  endfunction
endpackage

// File: rtl/hdins_trs_detect.sv
module hdins_trs_detect #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] word,
  output logic         end_ref,
  output logic         start_ref
);
  logic [W-1:0] h1, h2, h3;
  logic         prefix;

  always_ff @(posedge clk) begin
    if (rst) begin
      h1 <= '0;
      h2 <= '0;
      h3 <= '0;
    end else if (adv) begin
      h3 <= h2;
      h2 <= h1;
      h1 <= word;
    end
  end

  assign prefix    = (h3 == {W{1'b1}}) && (h2 == '0) && (h1 == '0);
  assign end_ref   = prefix &&  word[6];
  assign start_ref = prefix && !word[6];
endmodule

// File: rtl/hdins_crc18.sv
module hdins_crc18
  import hdins_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              clear,
  input  logic              en,
  input  logic [WORD_W-1:0] word,
  output logic [CRC_W-1:0]  crc
);
  always_ff @(posedge clk) begin
    if (rst)
      crc <= '0;
    else if (adv) begin
      if (clear)
        crc <= '0;
      else if (en)
        crc <= crc_step(crc, word);
    end
  end
endmodule

// File: rtl/hdins_slot_mux.sv
module hdins_slot_mux
  import hdins_pkg::*;
(
  input  slot_e             slot,
  input  logic [WORD_W-1:0] in_word,
  input  logic [LN_W-1:0]   ln,
  input  logic [CRC_W-1:0]  crc,
  output logic [WORD_W-1:0] out_word
);
  localparam int HALF = CRC_W / 2;

  always_comb begin
    unique case (slot)
      K_LN0:   out_word = {~ln[LN_LO-1], ln[LN_LO-1:0], 2'b00};
      K_LN1:   out_word = {1'b1, 3'b000, ln[LN_W-1:LN_LO], 2'b00};
      K_CRC0:  out_word = {~crc[HALF-1], crc[HALF-1:0]};
      K_CRC1:  out_word = {~crc[CRC_W-1], crc[CRC_W-1:HALF]};
      default: out_word = in_word;
    endcase
  end
endmodule

// File: rtl/hd_ln_crc_insert.sv
module hd_ln_crc_insert
  import hdins_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_y,
  input  logic [WORD_W-1:0] in_c,
  input  logic [LN_W-1:0]   in_ln,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_y,
  output logic [WORD_W-1:0] out_c
);
  localparam int NCH = 2;

  logic              acc;
  slot_e             slot_q, out_kind;
  logic [LN_W-1:0]   ln_q;
  logic              crc_en_q;
  logic              end_both, start_both;
  logic [NCH-1:0]    end_ch, start_ch;
  logic [WORD_W-1:0] ch_in  [NCH];
  logic [WORD_W-1:0] ch_out [NCH];
  logic [CRC_W-1:0]  ch_crc [NCH];
  logic              crc_clear, crc_feed;

  assign in_ready   = !out_valid || out_ready;
  assign acc        = in_valid && in_ready;
  assign ch_in[0]   = in_y;
  assign ch_in[1]   = in_c;
  assign end_both   = &end_ch;
  assign start_both = &start_ch;
  assign crc_clear  = (slot_q == K_PASS) && start_both;
  assign crc_feed   = crc_en_q && (slot_q == K_PASS || slot_q == K_LN0 || slot_q == K_LN1);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hdins_trs_detect #(.W(WORD_W)) u_det (
      .clk(clk), .rst(rst), .adv(acc), .word(ch_in[g]),
      .end_ref(end_ch[g]), .start_ref(start_ch[g])
    );
    hdins_slot_mux u_mux (
      .slot(slot_q), .in_word(ch_in[g]), .ln(ln_q), .crc(ch_crc[g]),
      .out_word(ch_out[g])
    );
    hdins_crc18 u_crc (
      .clk(clk), .rst(rst), .adv(acc), .clear(crc_clear), .en(crc_feed),
      .word(ch_out[g]), .crc(ch_crc[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= K_PASS;
      ln_q     <= '0;
      crc_en_q <= 1'b0;
    end else if (acc) begin
      unique case (slot_q)
        K_PASS: begin
          if (end_both) begin
            slot_q <= K_LN0;
            ln_q   <= in_ln;
          end
          if (start_both) crc_en_q <= 1'b1;
        end
        K_LN0:  slot_q <= K_LN1;
        K_LN1: begin
          slot_q   <= K_CRC0;
          crc_en_q <= 1'b0;
        end
        K_CRC0: slot_q <= K_CRC1;
        default: slot_q <= K_PASS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_c     <= '0;
      out_kind  <= K_PASS;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_y     <= ch_out[0];
      out_c     <= ch_out[1];
      out_kind  <= slot_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_y) && $stable(out_c));

  // R9
  crc_guard_bit_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_kind == K_CRC0 || out_kind == K_CRC1)
      |-> (out_y[9] != out_y[8]) && (out_c[9] != out_c[8]));

  // R8
  span_end_chk: assert property (@(posedge clk) disable iff (rst)
    acc && slot_q == K_LN1 |=> !crc_en_q);

  // R4
  no_insert_chk: assert property (@(posedge clk) disable iff (rst)
    acc && slot_q == K_PASS && !(end_ch[0] && end_ch[1]) |=> slot_q == K_PASS);

  // R6
  ln1_guard_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_kind == K_LN1 |-> out_y[9] && !out_y[8] && out_y[1:0] == 2'b00);
endmodule

// File: tb/test_hd_ln_crc_insert.sv
module test_hd_ln_crc_insert;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [9:0]  in_y, in_c, out_y, out_c;
  logic [10:0] in_ln;

  always #4 clk = ~clk;

  hd_ln_crc_insert i_hd_ln_crc_insert (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_y(in_y), .in_c(in_c), .in_ln(in_ln), .out_valid(out_valid),
    .out_ready(out_ready), .out_y(out_y), .out_c(out_c)
  );

  // {mode, line number, active words, seed}; mode 1: end reference on luma only
  localparam int NLINES = 8;
  localparam logic [36:0] LINE_TAB [NLINES] = '{
    {2'd0, 11'h000, 8'd12, 16'hACE1},
    {2'd0, 11'h7FF, 8'd20, 16'h1234},
    {2'd1, 11'h155, 8'd8,  16'hBEEF},
    {2'd0, 11'h2AA, 8'd40, 16'h0F0F},
    {2'd0, 11'h001, 8'd1,  16'h7777},
    {2'd1, 11'h400, 8'd5,  16'h5A5A},
    {2'd0, 11'h3C3, 8'd60, 16'hC001},
    {2'd0, 11'h07F, 8'd16, 16'h9E37}
  };
  localparam logic [17:0] TAPS = 18'h23000;

  int vectors = 0;
  int fails   = 0;
  logic [9:0]  sy [4096];
  logic [9:0]  sc [4096];
  logic [10:0] sl [4096];
  logic [9:0]  ey [4096];
  logic [9:0]  ec [4096];
  int          tg [4096];
  int          n_in = 0;
  logic [15:0] r;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [9:0] y, input logic [9:0] c, input logic [10:0] l, input int t);
    sy[n_in] = y; sc[n_in] = c; sl[n_in] = l; tg[n_in] = t;
    n_in++;
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic logic [17:0] crc_upd(input logic [17:0] c, input logic [9:0] w);
    logic [17:0] x = c;
    for (int b = 0; b < 10; b++) begin
      if (x[0] ^ w[b]) x = (x >> 1) ^ TAPS;
      else             x = x >> 1;
    end
    return x;
  endfunction

  task automatic build();
    logic [15:0] s;
    int md, nact;
    logic [10:0] l;
    for (int k = 0; k < NLINES; k++) begin
      md   = int'(LINE_TAB[k][36:35]);
      l    = LINE_TAB[k][34:24];
      nact = int'(LINE_TAB[k][23:16]);
      s    = LINE_TAB[k][15:0];
      for (int j = 0; j < 3; j++) put(10'h040, 10'h200, ~l, 0);
      put(10'h3FF, 10'h3FF, ~l, 0);
      put(10'h000, 10'h000, ~l, 0);
      put(10'h000, 10'h000, ~l, 0);
      put(10'h200, 10'h200, ~l, 0);
      for (int j = 0; j < nact; j++) begin
        s = nxt(s);
        put(10'h004 + 10'(s % 1008), 10'h004 + 10'((s >> 3) % 1008), ~l, 0);
      end
      put(10'h3FF, 10'h3FF, ~l, md);
      put(10'h000, 10'h000, ~l, md);
      put(10'h000, (md == 1) ? 10'h040 : 10'h000, ~l, md);
      put(10'h274, 10'h274, l, md);
      for (int j = 0; j < 4; j++) put(10'h080, 10'h100, ~l, md);
      put(10'h040, 10'h200, ~l, 0);
    end
  endtask

  task automatic model();
    int st = 0;
    bit en = 0;
    logic [17:0] cy = '0, cc = '0;
    logic [10:0] ll = '0;
    bit py, pc;
    for (int i = 0; i < n_in; i++) begin
      py = (i >= 3) && sy[i-3] == 10'h3FF && sy[i-2] == 0 && sy[i-1] == 0;
      pc = (i >= 3) && sc[i-3] == 10'h3FF && sc[i-2] == 0 && sc[i-1] == 0;
      case (st)
        0: begin
          ey[i] = sy[i]; ec[i] = sc[i];
          if (py && pc && !sy[i][6] && !sc[i][6]) begin
            cy = '0; cc = '0; en = 1;
          end else if (en) begin
            cy = crc_upd(cy, ey[i]); cc = crc_upd(cc, ec[i]);
          end
          if (py && pc && sy[i][6] && sc[i][6]) begin
            st = 1; ll = sl[i];
          end
        end
        1: begin
          ey[i] = {~ll[6], ll[6:0], 2'b00}; ec[i] = ey[i]; tg[i] = 2;
          if (en) begin cy = crc_upd(cy, ey[i]); cc = crc_upd(cc, ec[i]); end
          st = 2;
        end
        2: begin
          ey[i] = {1'b1, 3'b000, ll[10:7], 2'b00}; ec[i] = ey[i]; tg[i] = 3;
          if (en) begin cy = crc_upd(cy, ey[i]); cc = crc_upd(cc, ec[i]); end
          en = 0; st = 3;
        end
        3: begin
          ey[i] = {~cy[8], cy[8:0]}; ec[i] = {~cc[8], cc[8:0]}; tg[i] = 4; st = 4;
        end
        default: begin
          ey[i] = {~cy[17], cy[17:9]}; ec[i] = {~cc[17], cc[17:9]}; tg[i] = 4; st = 0;
        end
      endcase
    end
  endtask

  function automatic string tagname(input int t);
    case (t)
      0: return "R3";
      1: return "R4";
      2: return "R5 R10";
      3: return "R6";
      default: return "R7 R8 R9";
    endcase
  endfunction

  initial begin
    int iidx, oidx, cyc;
    bit pend;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    in_y = '0; in_c = '0; in_ln = '0;
    r = 16'h4D2B;
    build();
    model();
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && in_ready, "R1 in reset", {out_valid, in_ready}, 2'b01);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);

    iidx = 0; oidx = 0; cyc = 0; pend = 0;
    while (oidx < n_in && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      r = nxt(r);
      out_ready = (r[1:0] != 2'b00);
      if (!pend && iidx < n_in) pend = (r[3:2] != 2'b00);
      in_valid = pend;
      if (iidx < n_in) begin
        in_y = sy[iidx]; in_c = sc[iidx]; in_ln = sl[iidx];
      end
      #1;
      if (out_valid && out_ready) begin
        chk({out_y, out_c} == {ey[oidx], ec[oidx]}, tagname(tg[oidx]),
            {12'h0, out_y, out_c}, {12'h0, ey[oidx], ec[oidx]});
        oidx++;
      end
      if (in_valid && in_ready) begin
        iidx++;
        pend = 0;
      end
    end
    chk(oidx == n_in, "R2 word count / watchdog", oidx, n_in);

    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_y = 10'h123; in_c = 10'h321;
    #1;
    chk(in_ready, "R2 ready when empty", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid && out_y == 10'h123 && out_c == 10'h321 && !in_ready,
        "R2 one-cycle latency", {out_valid, in_ready, out_y, out_c}, {2'b10, 10'h123, 10'h321});
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid && out_y == 10'h123 && out_c == 10'h321, "R2 hold under stall",
        {out_valid, out_y, out_c}, {1'b1, 10'h123, 10'h321});
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk(in_ready, "R2 ready while draining", in_ready, 1);
    @(negedge clk);
    #1;
    chk(!out_valid, "R2 drained", out_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule